// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is one bank of general-purpose pins behind a word-addressed register port. Software drives pin levels and turns each pin's output driver on or off through dedicated write-one-to-set and write-one-to-clear aliases. Because of this, two agents can change different pins without a read-modify-write race. The current pin levels are read back through a two-flop synchroniser.

Every pin can raise an interrupt on a rising edge, on a falling edge, or on both. Each edge type has its own per-pin enable register. A detected edge latches a per-pin pending bit. Software clears a pending bit by writing a one to it. One registered interrupt line to the system reflects whether any pending bit is set. A register read returns its data on the clock edge that samples the read strobe.

Top module: `gpio_edge_bank`

## Requirements
- R1: After a synchronous reset, pin_out, pin_oe, both edge-enable registers, all pending bits and irq are zero.
- R2: Writing offset 0x14 sets every pin_out bit whose write-data bit is one and leaves the other bits unchanged.
- R3: Writing offset 0x18 clears every pin_out bit whose write-data bit is one and leaves the other bits unchanged.
- R4: Writing offset 0x1C sets driver-enable bits and writing 0x20 clears them, one bit per pin, with zero bits having no effect. The result appears on pin_oe and reads back at offset 0x04, where a one means the pin drives.
- R5: Offset 0x00 reads the pin levels after two synchronising flops. A level held stable for three clock cycles is returned by a read.
- R6: Offset 0x28 is a read/write rising-edge enable per pin. A 0-to-1 transition on an enabled pin sets its pending bit, which reads back at offset 0x0C.
- R7: Offset 0x2C is a read/write falling-edge enable per pin. A 1-to-0 transition on an enabled pin sets its pending bit.
- R8: A pin with both enables set latches both kinds of transition. A transition whose enable is clear leaves its pending bit at zero.
- R9: Writing offset 0x0C clears every pending bit whose write-data bit is one. Pending bits written with zero keep their value.
- R10: When a new edge on a pin is detected in the same cycle as a clear of that pin's pending bit, the pending bit remains set.
- R11: irq is high exactly when at least one pending bit is set, and it falls once the last pending bit is cleared.
- R12: Reads of unmapped offsets and of the four write-only aliases return zero. Writes to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (8) | Byte offset of the register |
| reg_wdata | input | NUM_PINS (32) | Write data, one bit per pin |
| reg_rdata | output | NUM_PINS (32) | Registered read data |
| pin_in | input | NUM_PINS (32) | Asynchronous pin levels |
| pin_out | output | NUM_PINS (32) | Output level per pin |
| pin_oe | output | NUM_PINS (32) | Output driver enable per pin |
| irq | output | 1 | Combined interrupt, high while any bit is pending |

## Verification
The hardest case to reach from the ports is a new edge being detected in the same cycle that a write-one-to-clear targets the same pin. The bench reaches it by first leaving a pin pending from a rising edge. It then drops that pin on a falling clock edge and counts exactly two further falling edges through the synchroniser, so the clear write is sampled on the very edge at which the new falling-edge detection lands. Reading pending afterwards separates a design that gives the edge priority from one that lets the clear win.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Byte offsets of the register window
  localparam int unsigned OFS_LEVEL    = 32'h00;
  localparam int unsigned OFS_DRV_STAT = 32'h04;
  localparam int unsigned OFS_PENDING  = 32'h0C;
  localparam int unsigned OFS_OUT_SET  = 32'h14;
  localparam int unsigned OFS_OUT_CLR  = 32'h18;
  localparam int unsigned OFS_DRV_SET  = 32'h1C;
  localparam int unsigned OFS_DRV_CLR  = 32'h20;
  localparam int unsigned OFS_RISE_EN  = 32'h28;
  localparam int unsigned OFS_FALL_EN  = 32'h2C;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_LEVEL,
    SEL_DRV_STAT,
    SEL_PENDING,
    SEL_OUT_SET,
    SEL_OUT_CLR,
    SEL_DRV_SET,
    SEL_DRV_CLR,
    SEL_RISE_EN,
    SEL_FALL_EN
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [31:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_LEVEL:    s = SEL_LEVEL;
      OFS_DRV_STAT: s = SEL_DRV_STAT;
      OFS_PENDING:  s = SEL_PENDING;
      OFS_OUT_SET:  s = SEL_OUT_SET;
      OFS_OUT_CLR:  s = SEL_OUT_CLR;
      OFS_DRV_SET:  s = SEL_DRV_SET;
      OFS_DRV_CLR:  s = SEL_DRV_CLR;
      OFS_RISE_EN:  s = SEL_RISE_EN;
      OFS_FALL_EN:  s = SEL_FALL_EN;
      default:      s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= g_stage[i-1].q;
      end
    end
  end

  assign dout = g_stage[STAGES-1].q;

endmodule

// File: rtl/gpio_edge_pend.sv
module gpio_edge_pend #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  input  logic [WIDTH-1:0] clr_mask,
  output logic [WIDTH-1:0] pending,
  output logic             irq
);

  logic [WIDTH-1:0] pend_nxt;
  logic             irq_q;

  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic prev_q;
    logic pend_q;
    logic hit;

    // A fresh edge outranks a clear arriving in the same cycle
    assign hit = (level[p] & ~prev_q & rise_en[p]) |
                 (~level[p] & prev_q & fall_en[p]);
    assign pend_nxt[p] = hit | (pend_q & ~clr_mask[p]);

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        prev_q <= level[p];
        pend_q <= pend_nxt[p];
      end
    end

    assign pending[p] = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend_nxt;
  end

  assign irq = irq_q;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  level,
  input  logic [WIDTH-1:0]  pending,
  output logic [WIDTH-1:0]  rdata,
  output logic [WIDTH-1:0]  out_val,
  output logic [WIDTH-1:0]  drv_en,
  output logic [WIDTH-1:0]  rise_en,
  output logic [WIDTH-1:0]  fall_en,
  output logic [WIDTH-1:0]  clr_mask
);

  reg_sel_e         sel;
  logic [WIDTH-1:0] out_q, drv_q, rise_q, fall_q, rdata_q;
  logic [WIDTH-1:0] rd_mux;

  assign sel = decode_offset(32'(addr));

  assign clr_mask = (wr && sel == SEL_PENDING) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      drv_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_OUT_SET: out_q  <= out_q | wdata;
        SEL_OUT_CLR: out_q  <= out_q & ~wdata;
        SEL_DRV_SET: drv_q  <= drv_q | wdata;
        SEL_DRV_CLR: drv_q  <= drv_q & ~wdata;
        SEL_RISE_EN: rise_q <= wdata;
        SEL_FALL_EN: fall_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_LEVEL:    rd_mux = level;
      SEL_DRV_STAT: rd_mux = drv_q;
      SEL_PENDING:  rd_mux = pending;
      SEL_RISE_EN:  rd_mux = rise_q;
      SEL_FALL_EN:  rd_mux = fall_q;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign rdata   = rdata_q;
  assign out_val = out_q;
  assign drv_en  = drv_q;
  assign rise_en = rise_q;
  assign fall_en = fall_q;

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [NUM_PINS-1:0] reg_wdata,
  output logic [NUM_PINS-1:0] reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);

  logic [NUM_PINS-1:0] lvl_sync;
  logic [NUM_PINS-1:0] pend_vec;
  logic [NUM_PINS-1:0] rise_vec;
  logic [NUM_PINS-1:0] fall_vec;
  logic [NUM_PINS-1:0] clr_vec;

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_in),
    .dout (lvl_sync)
  );

  gpio_bank_regs #(.WIDTH(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .level    (lvl_sync),
    .pending  (pend_vec),
    .rdata    (reg_rdata),
    .out_val  (pin_out),
    .drv_en   (pin_oe),
    .rise_en  (rise_vec),
    .fall_en  (fall_vec),
    .clr_mask (clr_vec)
  );

  gpio_edge_pend #(.WIDTH(NUM_PINS)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .level    (lvl_sync),
    .rise_en  (rise_vec),
    .fall_en  (fall_vec),
    .clr_mask (clr_vec),
    .pending  (pend_vec),
    .irq      (irq)
  );

endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [WIDTH-1:0]  reg_wdata,
  input logic [WIDTH-1:0]  pin_out,
  input logic [WIDTH-1:0]  pin_oe,
  input logic              irq,
  input logic [WIDTH-1:0]  pending
);

  reg_sel_e         sel;
  logic [WIDTH-1:0] wipe;

  assign sel  = decode_offset(32'(reg_addr));
  assign wipe = (reg_wr && sel == SEL_PENDING) ? reg_wdata : '0;

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out == '0 && pin_oe == '0 && !irq && pending == '0));

  a_r2_out_set: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && sel == SEL_OUT_SET) |=> ((pin_out & $past(reg_wdata)) == $past(reg_wdata)));

  a_r3_out_clr: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && sel == SEL_OUT_CLR) |=> ((pin_out & $past(reg_wdata)) == '0));

  a_r4_drv_set: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && sel == SEL_DRV_SET) |=> ((pin_oe & $past(reg_wdata)) == $past(reg_wdata)));

  a_r4_drv_clr: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && sel == SEL_DRV_CLR) |=> ((pin_oe & $past(reg_wdata)) == '0));

  a_r9_pend_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pending) & ~pending & ~$past(wipe)) == '0));

  a_r11_irq_any: assert property (@(posedge clk) disable iff (rst)
    irq == (pending != '0));

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.WIDTH(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .pending   (pend_vec)
);

// File: tb/gpio_edge_bank_test.sv
module gpio_edge_bank_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_edge_bank uut (
    .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_rd (reg_rd),
    .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe), .irq (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    reg_read(8'h28, v); check("R1 rise enable", v, 32'h0);
    reg_read(8'h2C, v); check("R1 fall enable", v, 32'h0);
    reg_read(8'h0C, v); check("R1 pending", v, 32'h0);
  endtask

  task automatic t_out_alias();
    reg_write(8'h14, 32'hA5A5_0F0F); check("R2 set", pin_out, 32'hA5A5_0F0F);
    reg_write(8'h14, 32'h0000_00F0); check("R2 set keeps others", pin_out, 32'hA5A5_0FFF);
    reg_write(8'h18, 32'h0F00_000F); check("R3 clear", pin_out, 32'hA0A5_0FF0);
    reg_write(8'h18, 32'h0);         check("R3 zero clear", pin_out, 32'hA0A5_0FF0);
  endtask

  task automatic t_drive();
    logic [31:0] v;
    reg_write(8'h1C, 32'hFFFF_0000); check("R4 drive set", pin_oe, 32'hFFFF_0000);
    reg_write(8'h20, 32'h00FF_0000); check("R4 drive clear", pin_oe, 32'hFF00_0000);
    reg_read(8'h04, v);              check("R4 drive readback", v, 32'hFF00_0000);
  endtask

  task automatic t_level();
    logic [31:0] v;
    pin_in = 32'h1234_5678; repeat (3) @(negedge clk);
    reg_read(8'h00, v); check("R5 level a", v, 32'h1234_5678);
    pin_in = 32'hEDCB_A987; repeat (3) @(negedge clk);
    reg_read(8'h00, v); check("R5 level b", v, 32'hEDCB_A987);
    pin_in = 32'h0; settle();
    reg_read(8'h0C, v); check("R8 disabled edges", v, 32'h0);
    check("R8 irq quiet", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    reg_write(8'h28, 32'h0000_00FF);
    reg_read(8'h28, v); check("R6 enable readback", v, 32'h0000_00FF);
    pin_in = 32'h0000_0101; settle();
    reg_read(8'h0C, v); check("R6 rising latched", v, 32'h0000_0001);
    pin_in = 32'h0; settle();
    reg_read(8'h0C, v); check("R6 fall ignored", v, 32'h0000_0001);
    reg_write(8'h0C, 32'h1);
    reg_read(8'h0C, v); check("R9 clear", v, 32'h0);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    reg_write(8'h2C, 32'h0000_FF00);
    reg_read(8'h2C, v); check("R7 enable readback", v, 32'h0000_FF00);
    pin_in = 32'h0000_0300; settle();
    reg_read(8'h0C, v); check("R7 rise ignored", v, 32'h0);
    pin_in = 32'h0; settle();
    reg_read(8'h0C, v); check("R7 falling latched", v, 32'h0000_0300);
    reg_write(8'h0C, 32'h0000_0100);
    reg_read(8'h0C, v); check("R9 partial clear", v, 32'h0000_0200);
    reg_write(8'h0C, 32'h0);
    reg_read(8'h0C, v); check("R9 zero write", v, 32'h0000_0200);
    reg_write(8'h0C, 32'h0000_0200);
  endtask

  task automatic t_both();
    logic [31:0] v;
    reg_write(8'h28, 32'h0010_00FF);
    reg_write(8'h2C, 32'h0010_FF00);
    pin_in = 32'h0010_0000; settle();
    reg_read(8'h0C, v); check("R8 both rise", v, 32'h0010_0000);
    reg_write(8'h0C, 32'h0010_0000);
    pin_in = 32'h0; settle();
    reg_read(8'h0C, v); check("R8 both fall", v, 32'h0010_0000);
    reg_write(8'h0C, 32'h0010_0000);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    pin_in = 32'h0010_0000; settle();
    pin_in = 32'h0;
    @(negedge clk);
    @(negedge clk);
    reg_write(8'h0C, 32'h0010_0000);
    reg_read(8'h0C, v); check("R10 edge beats clear", v, 32'h0010_0000);
    reg_write(8'h0C, 32'h0010_0000);
    reg_read(8'h0C, v); check("R10 later clear", v, 32'h0);
  endtask

  task automatic t_irq();
    pin_in = 32'h0000_0003; settle();
    check("R11 irq high", {31'h0, irq}, 32'h1);
    reg_write(8'h0C, 32'h1);
    check("R11 irq held", {31'h0, irq}, 32'h1);
    reg_write(8'h0C, 32'h2);
    check("R11 irq low", {31'h0, irq}, 32'h0);
    pin_in = 32'h0; settle();
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    reg_write(8'h08, 32'hFFFF_FFFF);
    reg_write(8'h30, 32'hFFFF_FFFF);
    reg_write(8'h24, 32'hFFFF_FFFF);
    check("R12 out untouched", pin_out, 32'hA0A5_0FF0);
    check("R12 oe untouched", pin_oe, 32'hFF00_0000);
    reg_read(8'h28, v); check("R12 enable untouched", v, 32'h0010_00FF);
    reg_read(8'h08, v); check("R12 hole reads zero", v, 32'h0);
    reg_read(8'h14, v); check("R12 alias reads zero", v, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_out_alias();
    t_drive();
    t_level();
    t_rise();
    t_fall();
    t_both();
    t_collision();
    t_irq();
    t_unmapped();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule